// File: doc/BRIEF.md
# Interrupt Post, Mask and Clear Controller

This block gathers up to 24 hardware interrupt request pulses into sticky "posted" bits. The posted bits sit in three 8-bit clear registers. Each posted bit is ANDed with a per-source mask bit to form a pending interrupt. A fixed-priority encoder selects the pending source with the lowest index and presents it to the CPU as a request flag and a 5-bit index. When the CPU pulses an acknowledge input, the posted bit of the source it is servicing is removed.

Software reaches the clear registers and four mask registers over a simple bus: address, write strobe, write data and a combinational read-data output. A write to a clear register normally clears bits. Bit 7 of the fourth mask register is a software-interrupt enable. While that bit is set, written ones post interrupts instead, which lets interrupt handlers be exercised without any peripheral activity.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset, all three clear registers (0xDA, 0xDB, 0xDC) and all four mask registers (0xE0 to 0xE3) read 0x00, and `irq_req` is 0.
- R2: A one-cycle pulse on `hw_irq[i]` sets posted bit i. That bit reads as 1 at bit i%8 of clear register 0xDA+i/8 from the next cycle on, and it stays set until it is cleared.
- R3: While the software-interrupt enable is 0, a write to a clear register clears every posted bit whose written bit is 0. Written ones leave their bits unchanged.
- R4: While the software-interrupt enable is 1, a write to a clear register posts every bit whose written bit is 1. Written zeros leave their bits unchanged.
- R5: The software-interrupt enable is bit 7 of mask register 0xE3. The value it held before a write governs that write.
- R6: A source whose mask bit is 0 still posts and still reads back as posted, but it never raises `irq_req`.
- R7: Each mask bit gates only its own source. Source i uses bit i%8 of mask register 0xE0+i/8.
- R8: While any source is pending, `irq_req` is 1 and `irq_idx` holds the lowest pending source index. Index 0 has the highest priority.
- R9: `irq_ack` held high at a clock edge while `irq_req` is 1 clears the posted bit of the source shown on `irq_idx` at that edge.
- R10: If a hardware pulse and a clear (by software write or by acknowledge) hit the same bit in the same cycle, the bit ends up set.
- R11: Sources 22 and 23 (bits 7 and 6 of 0xDC) are reserved. They always read 0 and cannot be posted by hardware or by software.
- R12: The mask registers read back the values last written to them, all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | 24 | Hardware request pulses, one per source |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | A pending interrupt exists |
| irq_idx | output | 5 | Index of the highest-priority pending source |
| irq_ack | input | 1 | CPU acknowledge of the source on `irq_idx` |

## Verification
The embedded properties check several things on every cycle. A hardware pulse always leaves its bit posted, even when a clear or an acknowledge lands in the same cycle. An acknowledge removes the serviced bit. Software-interrupt mode never removes a bit through a write. The reserved sources stay at zero. The encoder always names a pending source with nothing pending below it. The bench scenarios are what show the register-level meaning of writes: that written ones are inert in clear mode, that written zeros are inert in posting mode, and that the mode bit is taken from 0xE3 bit 7. They also show mask independence, mask readback and the full acknowledge sequence across three sources.

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl #(
  parameter int NGRP = 3,
  parameter int NSRC = 22,
  parameter logic [7:0] CLR_BASE = 8'hDA,
  parameter logic [7:0] MSK_BASE = 8'hE0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NGRP*8-1:0]             hw_irq,
  input  logic [7:0]                    bus_addr,
  input  logic                          bus_we,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  output logic                          irq_req,
  output logic [$clog2(NGRP*8)-1:0]     irq_idx,
  input  logic                          irq_ack
);
  localparam int NB   = NGRP * 8;
  localparam int IW   = $clog2(NB);
  localparam int NMSK = NGRP + 1;

  logic [NB-1:0]     posted, nxt, pend, valid;
  logic [NMSK*8-1:0] msk_q;
  logic              sw_en;

  for (genvar i = 0; i < NB; i++) begin : g_valid
    assign valid[i] = (i < NSRC);
  end

  assign sw_en = msk_q[NMSK*8-1];
  assign pend  = posted & msk_q[NB-1:0];

  always_comb begin
    nxt = posted;
    for (int g = 0; g < NGRP; g++) begin
      if (bus_we && bus_addr == CLR_BASE + 8'(g)) begin
        if (sw_en) nxt[g*8 +: 8] = nxt[g*8 +: 8] | bus_wdata;
        else       nxt[g*8 +: 8] = nxt[g*8 +: 8] & bus_wdata;
      end
    end
    if (irq_ack && irq_req) nxt[irq_idx] = 1'b0;
    nxt = (nxt | hw_irq) & valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) posted <= '0;
    else        posted <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msk_q <= '0;
    else begin
      for (int m = 0; m < NMSK; m++)
        if (bus_we && bus_addr == MSK_BASE + 8'(m)) msk_q[m*8 +: 8] <= bus_wdata;
    end
  end

  always_comb begin
    irq_idx = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (pend[i]) irq_idx = IW'(i);
  end
  assign irq_req = |pend;

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NGRP; g++)
      if (bus_addr == CLR_BASE + 8'(g)) bus_rdata = posted[g*8 +: 8];
    for (int m = 0; m < NMSK; m++)
      if (bus_addr == MSK_BASE + 8'(m)) bus_rdata = msk_q[m*8 +: 8];
  end

  a_r10_hw_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_irq & valid)) |=> ((posted & $past(hw_irq & valid)) == $past(hw_irq & valid)));

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !hw_irq[irq_idx]) |=> !posted[$past(irq_idx)]);

  a_r4_sw_mode_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !(irq_ack && irq_req)) |=> ((posted & $past(posted)) == $past(posted)));

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (posted & ~valid) == '0);

  a_r8_lowest_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_idx] && ((pend & ((NB'(1) << irq_idx) - NB'(1))) == '0)));

  a_r6_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq_req);
endmodule

// File: tb/sim_irq_post_ctrl.sv
module sim_irq_post_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] hw_irq = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic [4:0]  irq_idx;
  logic        irq_ack = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_post_ctrl u0 (.clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic [23:0] v);
    @(negedge clk); hw_irq = v;
    @(negedge clk); hw_irq = '0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 8'hDA; a <= 8'hDC; a++) begin rd(8'(a), d); chk("R1 clear reg", d, 0); end
    for (int a = 8'hE0; a <= 8'hE3; a++) begin rd(8'(a), d); chk("R1 mask reg", d, 0); end
    chk("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_hw_post();
    logic [7:0] d;
    pulse(24'h020208);
    repeat (3) @(negedge clk);
    rd(8'hDA, d); chk("R2 src3", d, 8'h08);
    rd(8'hDB, d); chk("R2 src9", d, 8'h02);
    rd(8'hDC, d); chk("R2 src17", d, 8'h02);
  endtask

  task automatic t_clear_mode();
    logic [7:0] d;
    wr(8'hDA, 8'hFF); rd(8'hDA, d); chk("R3 ones no effect", d, 8'h08);
    wr(8'hDA, 8'hF7); rd(8'hDA, d); chk("R3 zero clears", d, 8'h00);
    wr(8'hDB, 8'h00); wr(8'hDC, 8'h00);
    rd(8'hDB, d); chk("R3 clear grp1", d, 0);
  endtask

  task automatic t_sw_mode();
    logic [7:0] d;
    wr(8'hE3, 8'h80);
    rd(8'hE3, d); chk("R12 mask3 readback", d, 8'h80);
    wr(8'hDA, 8'h81); rd(8'hDA, d); chk("R4 R5 sw post", d, 8'h81);
    wr(8'hDA, 8'h00); rd(8'hDA, d); chk("R4 zeros ignored", d, 8'h81);
    wr(8'hDC, 8'hFF); rd(8'hDC, d); chk("R11 sw reserved", d, 8'h3F);
    wr(8'hE3, 8'h00);
    wr(8'hDA, 8'h00); wr(8'hDC, 8'h00);
    rd(8'hDA, d); chk("R5 clear mode back", d, 0);
    pulse(24'hC00000); rd(8'hDC, d); chk("R11 hw reserved", d, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    pulse(24'h000020);
    @(negedge clk);
    chk("R6 masked no req", irq_req, 0);
    rd(8'hDA, d); chk("R6 still posted", d, 8'h20);
    wr(8'hE0, 8'hDF); @(negedge clk);
    chk("R7 other bits no req", irq_req, 0);
    rd(8'hE0, d); chk("R12 mask0 readback", d, 8'hDF);
    wr(8'hE0, 8'h20); @(negedge clk);
    chk("R7 own bit req", irq_req, 1);
    chk("R8 idx 5", irq_idx, 5);
    wr(8'hDA, 8'h00); wr(8'hE0, 8'hFF); wr(8'hE1, 8'hFF); wr(8'hE2, 8'hFF);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    pulse(24'h101400);
    chk("R8 req", irq_req, 1);
    chk("R8 lowest idx", irq_idx, 10);
    ack();
    chk("R9 next idx", irq_idx, 12);
    rd(8'hDB, d); chk("R9 src10 cleared", d, 8'h10);
    ack(); chk("R9 idx 20", irq_idx, 20);
    ack(); chk("R9 none left", irq_req, 0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); bus_addr = 8'hDA; bus_wdata = 8'h00; bus_we = 1'b1; hw_irq = 24'h2;
    @(negedge clk); bus_we = 1'b0; hw_irq = '0;
    rd(8'hDA, d); chk("R10 hw beats clear", d, 8'h02);
    chk("R10 idx", irq_idx, 1);
    @(negedge clk); irq_ack = 1'b1; hw_irq = 24'h2;
    @(negedge clk); irq_ack = 1'b0; hw_irq = '0;
    rd(8'hDA, d); chk("R10 hw beats ack", d, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hw_post();
    t_clear_mode();
    t_sw_mode();
    t_mask();
    t_priority();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule